// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes over a two-wire clocked serial link: one data line and one serial clock line, with no start, stop or parity framing. Software puts a byte into a holding register and then clears a "holding register empty" flag. The block answers by copying the byte into its shift register and setting the empty flag again. It then sends the eight bits, bit 0 first. Because the holding register and the shift register are separate, software can supply the next byte while the current one is still on the wire.

The serial clock comes from one of two sources. In internal mode the block drives the clock itself, and each half period lasts a programmable number of system clocks. In external mode the clock comes from outside and is resynchronized into the system clock domain.

While the last bit of a frame is on the line, the block samples the empty flag. If software has already cleared it, the next frame follows with no idle gap. If not, the block raises a transmit-end flag, keeps the last bit on the data line and parks the clock high. Each of the two flags has a separate enable that turns it into an interrupt request. A transmit-enable input stops all activity and forces both flags high.

Top module: `sync_serial_tx`

## Requirements
- R1: After reset, empty_flag=1, end_flag=1, txd=1 and sck_out=1. With both interrupt enables at 0, both interrupt outputs are 0.
- R2: When empty_flag is 0, tx_en=1 and no frame is in progress, the next clock edge does all of the following: it copies the holding register into the shifter, sets empty_flag to 1, clears end_flag, puts bit 0 on txd and (in internal mode) drives sck_out low.
- R3: A frame is 8 bits sent bit 0 first. In internal mode each bit lasts 2*H system clocks, where H=half_div and a value of 0 acts as 1. txd changes only when sck_out goes low.
- R4: In internal mode sck_out is low for H clocks and then high for H clocks, exactly 8 times per frame. It stays high whenever no frame is in progress.
- R5: If empty_flag is 0 when the last bit's high phase ends, bit 0 of the next byte follows on the next clock with no idle cycle, and end_flag stays 0.
- R6: If empty_flag is 1 at the rising edge of the last bit, end_flag is set at that edge. After the bit ends, txd keeps the value of bit 7 and sck_out stays high.
- R7: empty_irq equals empty_flag AND empty_ie. end_irq equals end_flag AND end_ie.
- R8: In external mode (ext_clk_sel=1), sck_in passes through a two-stage synchronizer. The first falling edge after a load is ignored. After that, txd moves to the next bit only on a falling edge that follows a rising edge, and it stays unchanged through rising edges. sck_out=1 and sck_oe=0.
- R9: While tx_en=0, the block stops any frame, forces empty_flag=1, end_flag=1 and sck_out=1, ignores empty_clr and holds txd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; 0 stops the block and forces the flags high |
| ext_clk_sel | input | 1 | 1 selects the external serial clock on sck_in |
| half_div | input | DIV_W | Half period of the internal serial clock in system clocks (0 acts as 1) |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_din | input | DATA_W | Byte written into the holding register |
| empty_clr | input | 1 | Clears empty_flag to signal that the holding register holds new data |
| empty_ie | input | 1 | Interrupt enable for empty_flag |
| end_ie | input | 1 | Interrupt enable for end_flag |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Serial clock driven in internal mode; high when idle |
| sck_oe | output | 1 | High when the block drives the serial clock |
| txd | output | 1 | Serial data |
| empty_flag | output | 1 | Holding register empty |
| end_flag | output | 1 | Transmission ended |
| empty_irq | output | 1 | Holding-register-empty interrupt request |
| end_irq | output | 1 | Transmit-end interrupt request |

## Verification
The bench builds the block with DATA_W=8, SYNC_STAGES=2 and a two-bit divider (DIV_W=2). That makes every possible half_div value, including the value 0 that acts as 1, reachable in one sweep. Each divider value runs with all four combinations of the two interrupt enables. Every run streams three chained bytes and checks every system clock of every frame against a schedule the bench computes, so both the no-gap hand-over and the final parking of the lines are covered at each divider value. Separate runs cover the external clock path through the two-stage synchronizer and the effect of dropping tx_en in the middle of a frame.

// File: rtl/cstx_pkg.sv
package cstx_pkg;

   // Serial clock events seen in the system clock domain
   typedef struct packed {
      logic rise;
      logic fall;
   } sck_evt_t;

   localparam int unsigned DEF_DATA_W      = 8;
   localparam int unsigned DEF_DIV_W       = 8;
   localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/cstx_sync.sv
module cstx_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("cstx_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= RST_VAL;
         else        chain <= d;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cstx_sckgen.sv
module cstx_sckgen
   import cstx_pkg::*;
#(
   parameter int unsigned DIV_W       = DEF_DIV_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_sel,
   input  logic [DIV_W-1:0] half_div,
   input  logic             run,        // frame in progress and enabled
   input  logic             restart,    // a byte is being loaded this cycle
   input  logic             park_high,  // next falling moment ends the frame
   input  logic             sck_in,
   output sck_evt_t         evt,
   output logic             sck_lvl
);

   if (DIV_W < 1) begin : g_bad_div
      $error("cstx_sckgen: DIV_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cstx_sckgen: SYNC_STAGES must be at least 2");
   end

   // ---------------- external clock path ----------------
   logic sck_sync;
   logic sck_prev;
   logic ext_rise;
   logic ext_fall;

   cstx_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sck_in),
      .q     (sck_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b1;
      else        sck_prev <= sck_sync;
   end

   assign ext_rise = sck_sync & ~sck_prev;
   assign ext_fall = ~sck_sync & sck_prev;

   // ---------------- internal clock path ----------------
   logic [DIV_W-1:0] half_cnt;
   logic [DIV_W-1:0] half_last;
   logic             half_end;

   assign half_last = (half_div == '0) ? '0 : half_div - DIV_W'(1);
   assign half_end  = run && !ext_sel && (half_cnt == half_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_cnt <= '0;
         sck_lvl  <= 1'b1;
      end else if (restart && !ext_sel) begin
         half_cnt <= '0;
         sck_lvl  <= 1'b0;
      end else if (!run || ext_sel) begin
         half_cnt <= '0;
         sck_lvl  <= 1'b1;
      end else if (half_end) begin
         half_cnt <= '0;
         // low -> high always; high -> low unless the frame is over
         sck_lvl  <= ~sck_lvl | park_high;
      end else begin
         half_cnt <= half_cnt + DIV_W'(1);
      end
   end

   always_comb begin
      if (ext_sel) begin
         evt.rise = ext_rise;
         evt.fall = ext_fall;
      end else begin
         evt.rise = half_end & ~sck_lvl;
         evt.fall = half_end & sck_lvl;
      end
   end

endmodule

// File: rtl/cstx_shifter.sv
module cstx_shifter
   import cstx_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              hold_wr,
   input  logic [DATA_W-1:0] hold_din,
   input  logic              empty_clr,
   input  sck_evt_t          evt,
   output logic              txd,
   output logic              empty_flag,
   output logic              end_flag,
   output logic              busy,
   output logic              load_now,
   output logic              park_high
);

   localparam int unsigned BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int unsigned LAST_IX = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("cstx_shifter: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] shreg;
   logic [BIT_W-1:0]  bit_ix;
   logic              hi_seen;   // rising edge seen for the current bit
   logic              last_bit;
   logic              bit_done;

   assign last_bit  = (bit_ix == BIT_W'(LAST_IX));
   assign bit_done  = busy && evt.fall && hi_seen;
   assign load_now  = tx_en && !empty_flag && (!busy || (bit_done && last_bit));
   assign park_high = last_bit && empty_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= '0;
      else if (hold_wr) hold_q <= hold_din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         txd        <= 1'b1;
         bit_ix     <= '0;
         busy       <= 1'b0;
         hi_seen    <= 1'b0;
         empty_flag <= 1'b1;
         end_flag   <= 1'b1;
      end else if (!tx_en) begin
         busy       <= 1'b0;
         hi_seen    <= 1'b0;
         empty_flag <= 1'b1;
         end_flag   <= 1'b1;
      end else if (load_now) begin
         shreg      <= hold_q;
         txd        <= hold_q[0];
         bit_ix     <= '0;
         busy       <= 1'b1;
         hi_seen    <= 1'b0;
         empty_flag <= 1'b1;
         end_flag   <= 1'b0;
      end else begin
         if (empty_clr) empty_flag <= 1'b0;
         if (busy && evt.rise) begin
            hi_seen <= 1'b1;
            if (last_bit && empty_flag) end_flag <= 1'b1;
         end else if (bit_done) begin
            hi_seen <= 1'b0;
            if (last_bit) begin
               busy <= 1'b0;
            end else begin
               bit_ix <= bit_ix + BIT_W'(1);
               shreg  <= shreg >> 1;
               txd    <= shreg[1];
            end
         end
      end
   end

endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
   import cstx_pkg::*;
#(
   parameter int unsigned DATA_W      = DEF_DATA_W,
   parameter int unsigned DIV_W       = DEF_DIV_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              ext_clk_sel,
   input  logic [DIV_W-1:0]  half_div,
   input  logic              hold_wr,
   input  logic [DATA_W-1:0] hold_din,
   input  logic              empty_clr,
   input  logic              empty_ie,
   input  logic              end_ie,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              txd,
   output logic              empty_flag,
   output logic              end_flag,
   output logic              empty_irq,
   output logic              end_irq
);

   sck_evt_t sck_evt;
   logic     shift_busy;
   logic     load_now;
   logic     park_high;
   logic     sck_lvl;

   cstx_shifter #(
      .DATA_W (DATA_W)
   ) i_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_en      (tx_en),
      .hold_wr    (hold_wr),
      .hold_din   (hold_din),
      .empty_clr  (empty_clr),
      .evt        (sck_evt),
      .txd        (txd),
      .empty_flag (empty_flag),
      .end_flag   (end_flag),
      .busy       (shift_busy),
      .load_now   (load_now),
      .park_high  (park_high)
   );

   cstx_sckgen #(
      .DIV_W       (DIV_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_sckgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_sel   (ext_clk_sel),
      .half_div  (half_div),
      .run       (shift_busy & tx_en),
      .restart   (load_now),
      .park_high (park_high),
      .sck_in    (sck_in),
      .evt       (sck_evt),
      .sck_lvl   (sck_lvl)
   );

   assign sck_out   = (!tx_en || ext_clk_sel) ? 1'b1 : sck_lvl;
   assign sck_oe    = tx_en & ~ext_clk_sel;
   assign empty_irq = empty_flag & empty_ie;
   assign end_irq   = end_flag & end_ie;

endmodule

// File: rtl/sync_serial_tx_chk.sv
module sync_serial_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic ext_clk_sel,
   input logic txd,
   input logic sck_out,
   input logic empty_flag,
   input logic end_flag,
   input logic shift_busy
);

   // R2
   load_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !empty_flag && !shift_busy) |=> (empty_flag && !end_flag && shift_busy));

   // R3
   txd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !ext_clk_sel && !$past(ext_clk_sel) && !$stable(txd)) |-> !sck_out);

   // R6
   park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && end_flag && !shift_busy) |-> sck_out);

   // R9
   disable_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (empty_flag && end_flag && sck_out && !shift_busy));

   // R5
   no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && shift_busy && !empty_flag && $fell(sck_out) && !ext_clk_sel && $past(tx_en))
         |-> !end_flag || $past(empty_flag));

endmodule

bind sync_serial_tx sync_serial_tx_chk i_chk (.*);

// File: tb/test_sync_serial_tx.sv
module test_sync_serial_tx;

   localparam int DW = 8;
   localparam int VW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_en = 1'b0;
   logic          ext_clk_sel = 1'b0;
   logic [VW-1:0] half_div = '0;
   logic          hold_wr = 1'b0;
   logic [DW-1:0] hold_din = '0;
   logic          empty_clr = 1'b0;
   logic          empty_ie = 1'b0;
   logic          end_ie = 1'b0;
   logic          sck_in = 1'b1;
   logic          sck_out, sck_oe, txd, empty_flag, end_flag, empty_irq, end_irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] bq [0:2];

   always #2 clk = ~clk;

   sync_serial_tx #(.DATA_W(DW), .DIV_W(VW), .SYNC_STAGES(2)) i_sync_serial_tx (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ext_clk_sel(ext_clk_sel),
      .half_div(half_div), .hold_wr(hold_wr), .hold_din(hold_din),
      .empty_clr(empty_clr), .empty_ie(empty_ie), .end_ie(end_ie),
      .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .txd(txd),
      .empty_flag(empty_flag), .end_flag(end_flag),
      .empty_irq(empty_irq), .end_irq(end_irq));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int w = 0; w < n; w++) @(negedge clk);
   endtask

   // Streams three chained bytes in internal mode and checks every cycle
   task automatic run_int(input int hd, input int ie);
      int h;
      int per;
      h = (hd == 0) ? 1 : hd;
      per = 16 * h;
      for (int f = 0; f < 3; f++) bq[f] = 8'(hd * 37 + ie * 91 + f * 113 + 5);
      @(negedge clk);
      ext_clk_sel = 1'b0; half_div = VW'(hd);
      empty_ie = ie[0]; end_ie = ie[1];
      hold_wr = 1'b1; hold_din = bq[0]; empty_clr = 1'b1;
      @(negedge clk);
      hold_wr = 1'b0; empty_clr = 1'b0;
      chk(empty_flag == 1'b0, "R2 clear", int'(empty_flag), 0);
      @(negedge clk);
      for (int j = 0; j < 3 * per; j++) begin
         int f;
         int k;
         int ix;
         bit hi;
         bit last;
         bit e_end;
         bit e_empty;
         f = j / per; k = j % per; ix = k / (2 * h);
         hi = (k % (2 * h)) >= h;
         last = (f == 2);
         e_end = last && (k >= 15 * h);
         e_empty = !(!last && k >= 3);
         chk(txd == bq[f][ix], (k == 0) ? "R2 load bit0" : "R3 bit order",
             int'(txd), int'(bq[f][ix]));
         chk(sck_out == hi, "R4 clock phase", int'(sck_out), int'(hi));
         chk({empty_flag, end_flag} == {e_empty, e_end}, last ? "R6 flags" : "R5 flags",
             int'({empty_flag, end_flag}), int'({e_empty, e_end}));
         chk({empty_irq, end_irq} == {e_empty & ie[0], e_end & ie[1]}, "R7 irq",
             int'({empty_irq, end_irq}), int'({e_empty & ie[0], e_end & ie[1]}));
         if (k == 2 && !last) begin
            hold_wr = 1'b1; hold_din = bq[f+1]; empty_clr = 1'b1;
         end else begin
            hold_wr = 1'b0; empty_clr = 1'b0;
         end
         @(negedge clk);
      end
      for (int c = 0; c < 4; c++) begin
         chk({sck_out, txd, empty_flag, end_flag} == {1'b1, bq[2][7], 1'b1, 1'b1},
             "R6 idle park", int'({sck_out, txd, empty_flag, end_flag}),
             int'({1'b1, bq[2][7], 1'b1, 1'b1}));
         @(negedge clk);
      end
   endtask

   // One byte with the external serial clock
   task automatic run_ext(input logic [7:0] b);
      @(negedge clk);
      ext_clk_sel = 1'b1; sck_in = 1'b1;
      hold_wr = 1'b1; hold_din = b; empty_clr = 1'b1;
      @(negedge clk);
      hold_wr = 1'b0; empty_clr = 1'b0;
      wait_neg(2);
      chk({txd, empty_flag, end_flag} == {b[0], 1'b1, 1'b0}, "R8 ext load",
          int'({txd, empty_flag, end_flag}), int'({b[0], 1'b1, 1'b0}));
      chk({sck_out, sck_oe} == 2'b10, "R8 ext pins", int'({sck_out, sck_oe}), 2);
      sck_in = 1'b0; wait_neg(6);
      chk(txd == b[0], "R8 first fall ignored", int'(txd), int'(b[0]));
      for (int i = 0; i < 8; i++) begin
         sck_in = 1'b1; wait_neg(6);
         chk(txd == b[i], "R8 stable on rise", int'(txd), int'(b[i]));
         if (i == 7) chk(end_flag == 1'b1, "R6 ext end", int'(end_flag), 1);
         sck_in = 1'b0; wait_neg(6);
         if (i < 7) chk(txd == b[i+1], "R8 shift on fall", int'(txd), int'(b[i+1]));
         else chk({txd, end_flag} == {b[7], 1'b1}, "R6 ext hold bit7",
                  int'({txd, end_flag}), int'({b[7], 1'b1}));
      end
      sck_in = 1'b1; wait_neg(4);
      ext_clk_sel = 1'b0;
   endtask

   task automatic run_disable();
      logic held;
      @(negedge clk);
      half_div = 2'd2; ext_clk_sel = 1'b0;
      hold_wr = 1'b1; hold_din = 8'h96; empty_clr = 1'b1;
      @(negedge clk);
      hold_wr = 1'b0; empty_clr = 1'b0;
      wait_neg(6);
      held = txd;
      tx_en = 1'b0;
      @(negedge clk);
      chk({empty_flag, end_flag, sck_out} == 3'b111, "R9 forced",
          int'({empty_flag, end_flag, sck_out}), 7);
      empty_clr = 1'b1;
      @(negedge clk);
      empty_clr = 1'b0;
      @(negedge clk);
      chk(empty_flag == 1'b1, "R9 clear ignored", int'(empty_flag), 1);
      tx_en = 1'b1;
      wait_neg(10);
      chk({empty_flag, sck_out, txd} == {1'b1, 1'b1, held}, "R9 stays idle",
          int'({empty_flag, sck_out, txd}), int'({1'b1, 1'b1, held}));
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk({empty_flag, end_flag, txd, sck_out} == 4'b1111, "R1 reset state",
          int'({empty_flag, end_flag, txd, sck_out}), 15);
      chk({empty_irq, end_irq} == 2'b00, "R1 irq masked", int'({empty_irq, end_irq}), 0);
      tx_en = 1'b1;
      for (int hd = 0; hd < 4; hd++)
         for (int ie = 0; ie < 4; ie++) run_int(hd, ie);
      run_ext(8'hA5);
      run_ext(8'h3C);
      run_disable();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule